// File: doc/BRIEF.md
# Rotating Register Stack with Tags

This block holds eight 80-bit extended-precision words. Commands name them by their distance from a movable top-of-stack pointer: ST0 is the top, and STi lies i entries below it. A load pushes a new word onto the stack. A store copies ST0 out, and a store-with-pop also discards it. An exchange swaps ST0 with any STi. Indexed read and write reach any STi directly. Push and pop never move data. They only rotate a 3-bit pointer, so physical register (top+i) mod 8 serves as STi.

Each physical register carries a 2-bit tag: 00 marks it valid and 11 marks it empty. The control logic uses the tags to detect stack overflow and underflow. A second, flat view covers the same storage: eight 64-bit vector registers, where vector register n is the low 64 bits of physical register n whatever the pointer holds. Any vector access marks all tags valid, and an empty-vector-state command marks them all empty. A vector write also forces the top 16 bits of the register to all ones.

The block takes one command per cycle through a 4-bit opcode and a 3-bit index. All outputs are registered, so results appear one cycle after the command is sampled.

Top module: `fp_reg_stack`

## Requirements
- R1: While `rst` is high, the top pointer becomes 0, every tag becomes 11, and every data register, both data outputs and all strobe and error flags become 0.
- R2: Push (opcode 1), when the entry just above the top is empty, writes `cmd_word` there. That entry becomes the new ST0, every earlier STi becomes ST(i+1), the top pointer decrements modulo 8 and the new entry's tag becomes 00.
- R3: Store (opcode 2) drives ST0 on `st_data` with `st_data_vld` high one cycle after the command. The pointer, the tags and the data do not change.
- R4: Store-with-pop (opcode 3) outputs ST0 like store, sets the tag of the vacated entry to 11 and increments the top pointer modulo 8, so every STi becomes ST(i-1).
- R5: Read (opcode 5) outputs ST(`cmd_idx`) on `st_data`. Write (opcode 6) stores `cmd_word` into ST(`cmd_idx`) and sets its tag to 00 without moving the pointer.
- R6: Exchange (opcode 4) swaps the contents of ST0 and ST(`cmd_idx`). The pointer and the tags do not change.
- R7: A push whose target entry is not empty pulses `push_ovf` for one cycle. The pointer, the tags and the data stay unchanged.
- R8: A store, store-with-pop or read of an empty entry, or an exchange where either operand is empty, pulses `stk_unf` for one cycle. `st_data_vld` stays low, `st_data` holds its previous value and no state changes.
- R9: Init (opcode 7) sets every tag to 11 and the top pointer to 0. The data is kept.
- R10: Empty-vector-state (opcode 8) sets every tag to 11. The pointer and the data do not change.
- R11: Vector read (opcode 9) drives bits 63:0 of physical register `cmd_idx` on `vec_data` with `vec_data_vld` high, whatever the top pointer holds, and sets every tag to 00.
- R12: Vector write (opcode 10) stores `cmd_vec` into bits 63:0 of physical register `cmd_idx`, sets bits 79:64 to all ones and sets every tag to 00.
- R13: Opcode 0 and opcodes 11 to 15 change nothing. `tag_vec` bits [2p+1:2p] carry the tag of physical register p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 4 | Command opcode |
| cmd_idx | input | 3 | Stack-relative index i, or vector register number |
| cmd_word | input | 80 | Word for push and indexed write |
| cmd_vec | input | 64 | Word for vector write |
| st_data | output | 80 | Word from store, store-with-pop or read |
| st_data_vld | output | 1 | One-cycle strobe for `st_data` |
| vec_data | output | 64 | Word from vector read |
| vec_data_vld | output | 1 | One-cycle strobe for `vec_data` |
| push_ovf | output | 1 | Stack overflow pulse |
| stk_unf | output | 1 | Stack underflow pulse |
| top_ptr | output | 3 | Current top-of-stack physical index |
| tag_vec | output | 16 | Tags of all physical registers |

## Verification
Two views of the storage can act on the same physical register within one clock edge. A vector write changes the mantissa and forces the exponent of a register that may currently be any STi, and the same edge sets all eight tags. An exchange with index 0 uses both write ports on a single entry. The bench provokes both cases by mixing random vector writes with pushes and pops that rotate the pointer, and by issuing directed exchanges of ST0 with itself. Every stack-relative read, tag vector and pointer value is then compared against a model that holds physical registers and tags separately.

// File: rtl/fp_stack_pkg.sv
package fp_stack_pkg;
  localparam logic [1:0] TAG_VALID = 2'b00;
  localparam logic [1:0] TAG_EMPTY = 2'b11;

  typedef enum logic [3:0] {
    OP_NOP        = 4'd0,
    OP_PUSH       = 4'd1,
    OP_STORE      = 4'd2,
    OP_STOREP     = 4'd3,
    OP_XCHG       = 4'd4,
    OP_READ       = 4'd5,
    OP_WRITE      = 4'd6,
    OP_INIT       = 4'd7,
    OP_VEC_EMPTY  = 4'd8,
    OP_VEC_RD     = 4'd9,
    OP_VEC_WR     = 4'd10
  } stk_op_e;
endpackage

// File: rtl/stk_addr_map.sv
// Maps stack-relative names onto physical register indices (power-of-two depth).
module stk_addr_map #(
  parameter int IDX_W = 3
) (
  input  logic [IDX_W-1:0] top_i,
  input  logic [IDX_W-1:0] rel_i,
  output logic [IDX_W-1:0] ph_top_o,
  output logic [IDX_W-1:0] ph_rel_o,
  output logic [IDX_W-1:0] ph_push_o
);
  localparam logic [IDX_W-1:0] ONE = {{(IDX_W-1){1'b0}}, 1'b1};

  assign ph_top_o  = top_i;
  assign ph_rel_o  = top_i + rel_i;
  assign ph_push_o = top_i - ONE;
endmodule

// File: rtl/stk_tag_file.sv
// Per-register tags with a single-entry write and two bulk operations.
module stk_tag_file #(
  parameter int NREG  = 8,
  parameter int TAG_W = 2,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we_i,
  input  logic [IDX_W-1:0]      waddr_i,
  input  logic [TAG_W-1:0]      wval_i,
  input  logic                  all_empty_i,
  input  logic                  all_valid_i,
  output logic [NREG*TAG_W-1:0] tags_o
);
  import fp_stack_pkg::*;

  for (genvar g = 0; g < NREG; g++) begin : g_tag
    logic [TAG_W-1:0] tag_q;
    always_ff @(posedge clk) begin
      if (rst || all_empty_i) begin
        tag_q <= TAG_EMPTY;
      end else if (all_valid_i) begin
        tag_q <= TAG_VALID;
      end else if (we_i && (waddr_i == IDX_W'(g))) begin
        tag_q <= wval_i;
      end
    end
    assign tags_o[g*TAG_W +: TAG_W] = tag_q;
  end
endmodule

// File: rtl/stk_data_file.sv
// Physical data registers: two write ports (exchange), three combinational read ports.
module stk_data_file #(
  parameter int NREG   = 8,
  parameter int WORD_W = 80,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_a_i,
  input  logic [IDX_W-1:0]  wa_a_i,
  input  logic [WORD_W-1:0] din_a_i,
  input  logic              we_b_i,
  input  logic [IDX_W-1:0]  wa_b_i,
  input  logic [WORD_W-1:0] din_b_i,
  input  logic [IDX_W-1:0]  ra_0_i,
  input  logic [IDX_W-1:0]  ra_1_i,
  input  logic [IDX_W-1:0]  ra_2_i,
  output logic [WORD_W-1:0] rd_0_o,
  output logic [WORD_W-1:0] rd_1_o,
  output logic [WORD_W-1:0] rd_2_o
);
  logic [WORD_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= '0;
      end else if (we_b_i && (wa_b_i == IDX_W'(g))) begin
        regs[g] <= din_b_i;
      end else if (we_a_i && (wa_a_i == IDX_W'(g))) begin
        regs[g] <= din_a_i;
      end
    end
  end

  assign rd_0_o = regs[ra_0_i];
  assign rd_1_o = regs[ra_1_i];
  assign rd_2_o = regs[ra_2_i];
endmodule

// File: rtl/fp_reg_stack.sv
module fp_reg_stack #(
  parameter int NREG   = 8,
  parameter int WORD_W = 80,
  parameter int MANT_W = 64,
  parameter int TAG_W  = 2,
  localparam int IDX_W = $clog2(NREG),
  localparam int EXP_W = WORD_W - MANT_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [3:0]            cmd_op,
  input  logic [IDX_W-1:0]      cmd_idx,
  input  logic [WORD_W-1:0]     cmd_word,
  input  logic [MANT_W-1:0]     cmd_vec,
  output logic [WORD_W-1:0]     st_data,
  output logic                  st_data_vld,
  output logic [MANT_W-1:0]     vec_data,
  output logic                  vec_data_vld,
  output logic                  push_ovf,
  output logic                  stk_unf,
  output logic [IDX_W-1:0]      top_ptr,
  output logic [NREG*TAG_W-1:0] tag_vec
);
  import fp_stack_pkg::*;

  stk_op_e op;
  assign op = stk_op_e'(cmd_op);

  logic [IDX_W-1:0] top_q, top_nxt;
  logic [IDX_W-1:0] ph_top, ph_rel, ph_push;

  stk_addr_map #(.IDX_W(IDX_W)) u_map (
    .top_i    (top_q),
    .rel_i    (cmd_idx),
    .ph_top_o (ph_top),
    .ph_rel_o (ph_rel),
    .ph_push_o(ph_push)
  );

  // tag file controls
  logic             tag_we, all_empty, all_valid;
  logic [IDX_W-1:0] tag_wa;
  logic [TAG_W-1:0] tag_wv;
  logic [NREG*TAG_W-1:0] tags;

  stk_tag_file #(.NREG(NREG), .TAG_W(TAG_W)) u_tags (
    .clk        (clk),
    .rst        (rst),
    .we_i       (tag_we),
    .waddr_i    (tag_wa),
    .wval_i     (tag_wv),
    .all_empty_i(all_empty),
    .all_valid_i(all_valid),
    .tags_o     (tags)
  );

  logic emp_top, emp_rel, emp_push;
  assign emp_top  = (tags[int'(ph_top)  * TAG_W +: TAG_W] == TAG_EMPTY);
  assign emp_rel  = (tags[int'(ph_rel)  * TAG_W +: TAG_W] == TAG_EMPTY);
  assign emp_push = (tags[int'(ph_push) * TAG_W +: TAG_W] == TAG_EMPTY);

  // data file controls
  logic              we_a, we_b;
  logic [IDX_W-1:0]  wa_a, wa_b;
  logic [WORD_W-1:0] din_a, din_b;
  logic [WORD_W-1:0] rd_top, rd_rel, rd_vec;

  stk_data_file #(.NREG(NREG), .WORD_W(WORD_W)) u_data (
    .clk    (clk),
    .rst    (rst),
    .we_a_i (we_a),
    .wa_a_i (wa_a),
    .din_a_i(din_a),
    .we_b_i (we_b),
    .wa_b_i (wa_b),
    .din_b_i(din_b),
    .ra_0_i (ph_top),
    .ra_1_i (ph_rel),
    .ra_2_i (cmd_idx),
    .rd_0_o (rd_top),
    .rd_1_o (rd_rel),
    .rd_2_o (rd_vec)
  );

  logic              st_ld, vec_ld, ovf_nxt, unf_nxt;
  logic [WORD_W-1:0] st_sel;

  always_comb begin
    we_a      = 1'b0;
    wa_a      = ph_top;
    din_a     = cmd_word;
    we_b      = 1'b0;
    wa_b      = ph_rel;
    din_b     = rd_top;
    tag_we    = 1'b0;
    tag_wa    = ph_top;
    tag_wv    = TAG_VALID;
    all_empty = 1'b0;
    all_valid = 1'b0;
    top_nxt   = top_q;
    st_ld     = 1'b0;
    st_sel    = rd_top;
    vec_ld    = 1'b0;
    ovf_nxt   = 1'b0;
    unf_nxt   = 1'b0;
    case (op)
      OP_PUSH: begin
        if (!emp_push) begin
          ovf_nxt = 1'b1;
        end else begin
          we_a    = 1'b1;
          wa_a    = ph_push;
          tag_we  = 1'b1;
          tag_wa  = ph_push;
          top_nxt = ph_push;
        end
      end
      OP_STORE: begin
        if (emp_top) unf_nxt = 1'b1;
        else         st_ld   = 1'b1;
      end
      OP_STOREP: begin
        if (emp_top) begin
          unf_nxt = 1'b1;
        end else begin
          st_ld   = 1'b1;
          tag_we  = 1'b1;
          tag_wv  = TAG_EMPTY;
          top_nxt = ph_top + IDX_W'(1);
        end
      end
      OP_XCHG: begin
        if (emp_top || emp_rel) begin
          unf_nxt = 1'b1;
        end else begin
          we_a  = 1'b1;
          din_a = rd_rel;
          we_b  = 1'b1;
        end
      end
      OP_READ: begin
        if (emp_rel) begin
          unf_nxt = 1'b1;
        end else begin
          st_ld  = 1'b1;
          st_sel = rd_rel;
        end
      end
      OP_WRITE: begin
        we_a   = 1'b1;
        wa_a   = ph_rel;
        tag_we = 1'b1;
        tag_wa = ph_rel;
      end
      OP_INIT: begin
        all_empty = 1'b1;
        top_nxt   = '0;
      end
      OP_VEC_EMPTY: all_empty = 1'b1;
      OP_VEC_RD: begin
        vec_ld    = 1'b1;
        all_valid = 1'b1;
      end
      OP_VEC_WR: begin
        we_a      = 1'b1;
        wa_a      = cmd_idx;
        din_a     = {{EXP_W{1'b1}}, cmd_vec};
        all_valid = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      top_q        <= '0;
      st_data      <= '0;
      st_data_vld  <= 1'b0;
      vec_data     <= '0;
      vec_data_vld <= 1'b0;
      push_ovf     <= 1'b0;
      stk_unf      <= 1'b0;
    end else begin
      top_q        <= top_nxt;
      st_data_vld  <= st_ld;
      vec_data_vld <= vec_ld;
      push_ovf     <= ovf_nxt;
      stk_unf      <= unf_nxt;
      if (st_ld)  st_data  <= st_sel;
      if (vec_ld) vec_data <= rd_vec[MANT_W-1:0];
    end
  end

  assign top_ptr = top_q;
  assign tag_vec = tags;
endmodule

// File: rtl/fp_reg_stack_chk.sv
module fp_reg_stack_chk #(
  parameter int NREG  = 8,
  parameter int TAG_W = 2,
  localparam int IDX_W = $clog2(NREG)
) (
  input logic                  clk,
  input logic                  rst,
  input logic [3:0]            cmd_op,
  input logic [IDX_W-1:0]      top_ptr,
  input logic [NREG*TAG_W-1:0] tag_vec,
  input logic                  st_data_vld,
  input logic                  vec_data_vld,
  input logic                  push_ovf,
  input logic                  stk_unf
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (top_ptr == '0 && (&tag_vec)));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push_ovf |-> ($stable(top_ptr) && $stable(tag_vec)));

  // R8
  underflow_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    stk_unf |-> (!st_data_vld && !push_ovf));

  // R4
  pop_rotates_chk: assert property (@(posedge clk) disable iff (rst)
    (st_data_vld && $past(cmd_op) == 4'd3) |-> (top_ptr == IDX_W'($past(top_ptr) + 1'b1)));

  // R9
  init_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == 4'd7) |=> (top_ptr == '0 && (&tag_vec)));

  // R10
  vec_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == 4'd8) |=> ((&tag_vec) && $stable(top_ptr)));

  // R11
  vec_read_tags_chk: assert property (@(posedge clk) disable iff (rst)
    vec_data_vld |-> (tag_vec == '0));
endmodule

bind fp_reg_stack fp_reg_stack_chk #(.NREG(NREG), .TAG_W(TAG_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_op      (cmd_op),
  .top_ptr     (top_ptr),
  .tag_vec     (tag_vec),
  .st_data_vld (st_data_vld),
  .vec_data_vld(vec_data_vld),
  .push_ovf    (push_ovf),
  .stk_unf     (stk_unf)
);

// File: tb/test_fp_reg_stack.sv
`timescale 1ns/100ps
module test_fp_reg_stack;
  localparam logic [3:0] C_NOP = 4'd0, C_PUSH = 4'd1, C_ST = 4'd2, C_STP = 4'd3,
                         C_XCH = 4'd4, C_RD = 4'd5, C_WR = 4'd6, C_INIT = 4'd7,
                         C_VEMP = 4'd8, C_VRD = 4'd9, C_VWR = 4'd10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cmd_op = '0;
  logic [2:0]  cmd_idx = '0;
  logic [79:0] cmd_word = '0;
  logic [63:0] cmd_vec = '0;
  logic [79:0] st_data;
  logic        st_data_vld;
  logic [63:0] vec_data;
  logic        vec_data_vld, push_ovf, stk_unf;
  logic [2:0]  top_ptr;
  logic [15:0] tag_vec;

  always #2.5 clk = ~clk;

  fp_reg_stack i_fp_reg_stack (
    .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
    .cmd_word(cmd_word), .cmd_vec(cmd_vec), .st_data(st_data),
    .st_data_vld(st_data_vld), .vec_data(vec_data), .vec_data_vld(vec_data_vld),
    .push_ovf(push_ovf), .stk_unf(stk_unf), .top_ptr(top_ptr), .tag_vec(tag_vec)
  );

  int checks = 0;
  int errors = 0;

  // reference model
  logic [79:0] m_reg [8];
  logic [1:0]  m_tag [8];
  int          m_top;
  logic [79:0] e_st;
  logic        e_stv;
  logic [63:0] e_vec;
  logic        e_vecv, e_ovf, e_unf;

  function automatic logic [15:0] tags_flat();
    logic [15:0] v;
    for (int p = 0; p < 8; p++) v[2*p +: 2] = m_tag[p];
    return v;
  endfunction

  function automatic string req_of(logic [3:0] op);
    case (op)
      C_PUSH: return "R2/R7";
      C_ST:   return "R3/R8";
      C_STP:  return "R4/R8";
      C_XCH:  return "R6/R8";
      C_RD:   return "R5/R8";
      C_WR:   return "R5";
      C_INIT: return "R9";
      C_VEMP: return "R10";
      C_VRD:  return "R11";
      C_VWR:  return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int p = 0; p < 8; p++) begin m_reg[p] = '0; m_tag[p] = 2'b11; end
    m_top = 0; e_st = '0; e_stv = 0; e_vec = '0; e_vecv = 0; e_ovf = 0; e_unf = 0;
  endtask

  task automatic model_step(input logic [3:0] op, input int idx,
                            input logic [79:0] w, input logic [63:0] v);
    int rel, psh;
    logic [79:0] t;
    rel = (m_top + idx) & 7;
    psh = (m_top + 7) & 7;
    e_stv = 0; e_vecv = 0; e_ovf = 0; e_unf = 0;
    case (op)
      C_PUSH: if (m_tag[psh] != 2'b11) e_ovf = 1;
              else begin m_reg[psh] = w; m_tag[psh] = 2'b00; m_top = psh; end
      C_ST:   if (m_tag[m_top] == 2'b11) e_unf = 1;
              else begin e_st = m_reg[m_top]; e_stv = 1; end
      C_STP:  if (m_tag[m_top] == 2'b11) e_unf = 1;
              else begin
                e_st = m_reg[m_top]; e_stv = 1; m_tag[m_top] = 2'b11;
                m_top = (m_top + 1) & 7;
              end
      C_XCH:  if (m_tag[m_top] == 2'b11 || m_tag[rel] == 2'b11) e_unf = 1;
              else begin t = m_reg[m_top]; m_reg[m_top] = m_reg[rel]; m_reg[rel] = t; end
      C_RD:   if (m_tag[rel] == 2'b11) e_unf = 1;
              else begin e_st = m_reg[rel]; e_stv = 1; end
      C_WR:   begin m_reg[rel] = w; m_tag[rel] = 2'b00; end
      C_INIT: begin for (int p = 0; p < 8; p++) m_tag[p] = 2'b11; m_top = 0; end
      C_VEMP: for (int p = 0; p < 8; p++) m_tag[p] = 2'b11;
      C_VRD:  begin
                e_vec = m_reg[idx][63:0]; e_vecv = 1;
                for (int p = 0; p < 8; p++) m_tag[p] = 2'b00;
              end
      C_VWR:  begin
                m_reg[idx] = {16'hFFFF, v};
                for (int p = 0; p < 8; p++) m_tag[p] = 2'b00;
              end
      default: ;
    endcase
  endtask

  // drive at a falling edge, let one rising edge take it, check at the next falling edge
  task automatic run(input logic [3:0] op, input int idx,
                     input logic [79:0] w, input logic [63:0] v);
    string r;
    cmd_op = op; cmd_idx = 3'(idx); cmd_word = w; cmd_vec = v;
    model_step(op, idx, w, v);
    r = req_of(op);
    @(posedge clk);
    @(negedge clk);
    cmd_op = C_NOP;
    chk(st_data_vld == e_stv, r, "st_data_vld", 80'(st_data_vld), 80'(e_stv));
    chk(st_data == e_st, r, "st_data", st_data, e_st);
    chk(vec_data_vld == e_vecv, r, "vec_data_vld", 80'(vec_data_vld), 80'(e_vecv));
    chk(vec_data == e_vec, r, "vec_data", 80'(vec_data), 80'(e_vec));
    chk(push_ovf == e_ovf, r, "push_ovf", 80'(push_ovf), 80'(e_ovf));
    chk(stk_unf == e_unf, r, "stk_unf", 80'(stk_unf), 80'(e_unf));
    chk(top_ptr == 3'(m_top), r, "top_ptr", 80'(top_ptr), 80'(m_top));
    chk(tag_vec == tags_flat(), r, "tag_vec", 80'(tag_vec), 80'(tags_flat()));
  endtask

  function automatic logic [79:0] rnd80();
    return {16'($urandom), $urandom, $urandom};
  endfunction

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(top_ptr == 3'd0, "R1", "top_ptr", 80'(top_ptr), 80'd0);
    chk(tag_vec == 16'hFFFF, "R1", "tag_vec", 80'(tag_vec), 80'hFFFF);
    chk(!st_data_vld && !push_ovf && !stk_unf && !vec_data_vld, "R1", "flags",
        80'({st_data_vld, push_ovf, stk_unf, vec_data_vld}), 80'd0);
    rst = 1'b0;
    @(negedge clk);

    // R2, R5, R6, R3, R4 directed
    run(C_PUSH, 0, 80'h1111_0000_0000_0000_00AA, '0);
    run(C_PUSH, 0, 80'h2222_0000_0000_0000_00BB, '0);
    run(C_RD, 1, '0, '0);          // R5: ST1 is the first push
    run(C_WR, 1, 80'h3333_0000_0000_0000_00CC, '0);
    run(C_XCH, 1, '0, '0);         // R6
    run(C_XCH, 0, '0, '0);         // R6: ST0 with itself
    run(C_ST, 0, '0, '0);          // R3
    run(C_STP, 0, '0, '0);         // R4
    run(C_STP, 0, '0, '0);
    run(C_STP, 0, '0, '0);         // R8: pop of empty
    run(C_RD, 3, '0, '0);          // R8: read of empty
    // R7: fill all eight, then one more
    for (int k = 0; k < 9; k++) run(C_PUSH, 0, rnd80(), '0);
    run(C_XCH, 7, '0, '0);
    // R12, R11: vector aliasing across a rotated top
    run(C_STP, 0, '0, '0);
    run(C_VWR, 3, '0, 64'h0123_4567_89AB_CDEF);
    run(C_VRD, 3, '0, '0);
    run(C_RD, (3 - m_top) & 7, '0, '0);
    run(C_VEMP, 0, '0, '0);        // R10
    run(C_ST, 0, '0, '0);
    run(C_VRD, 5, '0, '0);
    run(C_INIT, 0, '0, '0);        // R9
    run(C_VRD, 0, '0, '0);
    run(4'd13, 2, rnd80(), 64'hFFFF);  // R13
    run(C_NOP, 0, '0, '0);

    // constrained random mix
    for (int n = 0; n < 1500; n++) begin
      int sel;
      logic [3:0] op;
      sel = int'($urandom_range(0, 19));
      if (sel < 6)       op = C_PUSH;
      else if (sel < 9)  op = C_STP;
      else if (sel == 19) op = 4'(11 + $urandom_range(0, 4));
      else               op = 4'($urandom_range(0, 10));
      run(op, int'($urandom_range(0, 7)), rnd80(), {$urandom, $urandom});
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule